// File: doc/BRIEF.md
# Sequential Backprop Error Generator

This block is the digital half of a neural core's training unit. It turns digitized neuron quantities into 8-bit error terms (deltas), one neuron per clock cycle. A single multiplier and a single derivative table are shared by every neuron. A one-hot select register walks across the layer, and the selected neuron's analog value is routed onto the shared inputs. The converters and the crossbar sit outside the block and appear here as plain digital inputs.

A pass is launched by a start pulse together with an operation code, and it takes one cycle per neuron. In output mode, the incoming target-minus-output difference is multiplied by the activation slope, which is looked up from the quantized dot product, and the result is stored as that neuron's delta. In capture mode, the looked-up slopes are saved during the forward step. In hidden mode, each back-propagated sum is scaled by the slope saved for its neuron. The activation being modelled is piecewise: flat at +0.5 above an input of 2, flat at -0.5 below -2, and x/4 between the two. Its slope is therefore 1/4 inside that band and zero outside it.

Top module: `bpe_error_gen`

## Requirements
- R1: After reset, busy, done and selOneHot are 0 and every delta field of deltaBus reads 0.
- R2: The slope table takes dpIn as a signed two's-complement code with 4 fractional bits. It returns 16 (1/4 with 6 fractional bits) for codes -31 through 31, and 0 for every other code, including exactly -32 and +32.
- R3: Output mode (opMode 2'b00). Neuron k's delta is floor((sampleIn*slope(dpIn) + 32) / 64), saturated to -128..127. Both operands are signed with 6 fractional bits. The delta lands in deltaBus[8k+7:8k].
- R4: Capture mode (opMode 2'b01) stores slope(dpIn) for each neuron in an internal buffer and leaves every deltaBus field unchanged.
- R5: Hidden mode (opMode 2'b10) uses the R3 formula with the slope saved for neuron k in the last capture pass, and ignores dpIn.
- R6: A start pulse accepted while idle sets selOneHot to 1 (bit 0) in the next cycle. The set bit then moves up one position per cycle. Neuron k's inputs are sampled at the clock edge that ends the cycle in which bit k is set.
- R7: done is a one-cycle pulse in the cycle after the last neuron's cycle, and busy is low in that cycle. busy is high exactly while a select bit is set.
- R8: A start pulse that arrives while busy is ignored. The running pass continues in its original mode and keeps its timing.
- R9: A start pulse with opMode 2'b11 is ignored. busy stays low and deltaBus is unchanged.
- R10: Only the selected neuron's delta field is written. A field keeps its old value until its own cycle, and all fields hold while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches a pass when idle |
| opMode | input | 2 | 00 output, 01 capture, 10 hidden, 11 reserved |
| sampleIn | input | 8 | Selected neuron's difference or back-propagated sum, signed, 6 fractional bits |
| dpIn | input | 8 | Selected neuron's quantized dot product, signed, 4 fractional bits |
| selOneHot | output | 8 | One-hot neuron select, steering the external multiplexer |
| busy | output | 1 | Pass in progress |
| done | output | 1 | One-cycle end-of-pass pulse |
| deltaBus | output | 64 | Delta buffer, neuron k in bits 8k+7:8k |

## Verification
The hardest case to reach from the ports is a hidden pass in which the stored slope and the slope the current dpIn would give disagree. Only that case shows that the saved value, and not a fresh lookup, is used. The bench therefore runs a capture pass with a mix of in-band and saturated codes. It then runs a hidden pass that drives each neuron's dpIn to the opposite category, so that every expected delta depends on the captured slope alone. A second subtle case is a start pulse with a different mode that arrives partway through a pass. The bench injects one at neuron 3 and then checks that the remaining deltas still follow the original mode.

// File: rtl/bpe_pkg.sv
package bpe_pkg;

  typedef enum logic [1:0] {
    OP_OUTPUT   = 2'b00,
    OP_CAPTURE  = 2'b01,
    OP_HIDDEN   = 2'b10,
    OP_RESERVED = 2'b11
  } opMode_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic wrDelta;
    logic wrDeriv;
    logic useStored;
  } dpStrobe_t;

endpackage

// File: rtl/bpe_deriv_table.sv
module bpe_deriv_table #(
  parameter int DP_W     = 8,
  parameter int DP_FRAC  = 4,
  parameter int VAL_W    = 8,
  parameter int VAL_FRAC = 6
) (
  input  logic [DP_W-1:0]  dpCode,
  output logic [VAL_W-1:0] derivVal
);
  localparam int DEPTH = 1 << DP_W;
  localparam int LIMIT = 2 << DP_FRAC;               // |x| = 2 in code units
  localparam logic [VAL_W-1:0] QUARTER = VAL_W'(1 << (VAL_FRAC - 2));

  logic [VAL_W-1:0] rom [DEPTH];

  // slope of the saturating activation, computed per entry
  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    localparam int SIGNEDV = (i < DEPTH / 2) ? i : i - DEPTH;
    assign rom[i] = (SIGNEDV > -LIMIT && SIGNEDV < LIMIT) ? QUARTER : '0;
  end

  assign derivVal = rom[dpCode];
endmodule

// File: rtl/bpe_control.sv
module bpe_control
  import bpe_pkg::*;
#(
  parameter int NUM_NEURONS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic [1:0]             opMode,
  output logic [NUM_NEURONS-1:0] selQ,
  output logic                   busyQ,
  output logic                   doneQ,
  output dpStrobe_t              strobe
);
  opMode_e modeQ;
  opMode_e modeIn;

  assign modeIn = opMode_e'(opMode);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      modeQ <= OP_OUTPUT;
    end else begin
      doneQ <= 1'b0;
      if (!busyQ) begin
        if (start && modeIn != OP_RESERVED) begin
          busyQ <= 1'b1;
          selQ  <= NUM_NEURONS'(1);
          modeQ <= modeIn;
        end
      end else if (selQ[NUM_NEURONS-1]) begin
        busyQ <= 1'b0;
        selQ  <= '0;
        doneQ <= 1'b1;
      end else begin
        selQ <= selQ << 1;
      end
    end
  end

  always_comb begin
    strobe.wrDelta   = busyQ && (modeQ == OP_OUTPUT || modeQ == OP_HIDDEN);
    strobe.wrDeriv   = busyQ && (modeQ == OP_CAPTURE);
    strobe.useStored = (modeQ == OP_HIDDEN);
  end
endmodule

// File: rtl/bpe_datapath.sv
module bpe_datapath
  import bpe_pkg::*;
#(
  parameter int NUM_NEURONS = 8,
  parameter int ERR_W       = 8,
  parameter int ERR_FRAC    = 6,
  parameter int DP_W        = 8,
  parameter int DP_FRAC     = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  dpStrobe_t                    strobe,
  input  logic [NUM_NEURONS-1:0]       sel,
  input  logic [ERR_W-1:0]             sampleIn,
  input  logic [DP_W-1:0]              dpIn,
  output logic [NUM_NEURONS*ERR_W-1:0] deltaBus
);
  localparam int PW = 2 * ERR_W + 1;
  localparam logic signed [PW-1:0] ROUND_ADD = PW'(1 << (ERR_FRAC - 1));
  localparam logic signed [PW-1:0] MAX_V = PW'((1 << (ERR_W - 1)) - 1);
  localparam logic signed [PW-1:0] MIN_V = -PW'(1 << (ERR_W - 1));

  logic [ERR_W-1:0] derivBuf [NUM_NEURONS];
  logic [ERR_W-1:0] deltaBuf [NUM_NEURONS];
  logic [ERR_W-1:0] tableVal;
  logic [ERR_W-1:0] storedVal;
  logic [ERR_W-1:0] derivSel;
  logic signed [2*ERR_W-1:0] product;
  logic signed [PW-1:0]      rounded;
  logic signed [PW-1:0]      shifted;
  logic [ERR_W-1:0]          newDelta;

  bpe_deriv_table #(
    .DP_W(DP_W), .DP_FRAC(DP_FRAC), .VAL_W(ERR_W), .VAL_FRAC(ERR_FRAC)
  ) u_table (
    .dpCode(dpIn),
    .derivVal(tableVal)
  );

  // one-hot OR multiplexer over the stored slopes
  always_comb begin
    storedVal = '0;
    for (int k = 0; k < NUM_NEURONS; k++) begin
      if (sel[k]) storedVal = storedVal | derivBuf[k];
    end
  end

  assign derivSel = strobe.useStored ? storedVal : tableVal;

  // shared multiply, round half up, saturate
  always_comb begin
    product = $signed(sampleIn) * $signed(derivSel);
    rounded = PW'(product) + ROUND_ADD;
    shifted = rounded >>> ERR_FRAC;
    if (shifted > MAX_V)      newDelta = MAX_V[ERR_W-1:0];
    else if (shifted < MIN_V) newDelta = MIN_V[ERR_W-1:0];
    else                      newDelta = shifted[ERR_W-1:0];
  end

  for (genvar k = 0; k < NUM_NEURONS; k++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        derivBuf[k] <= '0;
        deltaBuf[k] <= '0;
      end else begin
        if (sel[k] && strobe.wrDeriv) derivBuf[k] <= tableVal;
        if (sel[k] && strobe.wrDelta) deltaBuf[k] <= newDelta;
      end
    end
    assign deltaBus[k*ERR_W +: ERR_W] = deltaBuf[k];
  end
endmodule

// File: rtl/bpe_error_gen.sv
module bpe_error_gen
  import bpe_pkg::*;
#(
  parameter int NUM_NEURONS = 8,
  parameter int ERR_W       = 8,
  parameter int ERR_FRAC    = 6,
  parameter int DP_W        = 8,
  parameter int DP_FRAC     = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [1:0]                   opMode,
  input  logic [ERR_W-1:0]             sampleIn,
  input  logic [DP_W-1:0]              dpIn,
  output logic [NUM_NEURONS-1:0]       selOneHot,
  output logic                         busy,
  output logic                         done,
  output logic [NUM_NEURONS*ERR_W-1:0] deltaBus
);
  dpStrobe_t strobe;

  bpe_control #(.NUM_NEURONS(NUM_NEURONS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .opMode(opMode),
    .selQ(selOneHot), .busyQ(busy), .doneQ(done), .strobe(strobe)
  );

  bpe_datapath #(
    .NUM_NEURONS(NUM_NEURONS), .ERR_W(ERR_W), .ERR_FRAC(ERR_FRAC),
    .DP_W(DP_W), .DP_FRAC(DP_FRAC)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sel(selOneHot),
    .sampleIn(sampleIn), .dpIn(dpIn), .deltaBus(deltaBus)
  );
endmodule

// File: rtl/bpe_error_gen_chk.sv
module bpe_error_gen_chk #(
  parameter int NUM_NEURONS = 8,
  parameter int ERR_W       = 8
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         start,
  input logic [1:0]                   opMode,
  input logic [NUM_NEURONS-1:0]       selOneHot,
  input logic                         busy,
  input logic                         done,
  input logic [NUM_NEURONS*ERR_W-1:0] deltaBus
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(selOneHot)); // R6
  AST_BUSY_MATCHES_SEL: assert property (@(posedge clk) disable iff (!rstN)
    busy == (selOneHot != '0)); // R7
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opMode != 2'b11) |=> selOneHot == NUM_NEURONS'(1)); // R6
  AST_SEL_SHIFTS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !selOneHot[NUM_NEURONS-1]) |=> selOneHot == ($past(selOneHot) << 1)); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rstN)
    selOneHot[NUM_NEURONS-1] |=> (done && !busy)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7
  AST_RESERVED_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && opMode == 2'b11) |=> !busy); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> $stable(deltaBus)); // R10
endmodule

bind bpe_error_gen bpe_error_gen_chk #(
  .NUM_NEURONS(NUM_NEURONS), .ERR_W(ERR_W)
) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opMode(opMode),
  .selOneHot(selOneHot), .busy(busy), .done(done), .deltaBus(deltaBus)
);

// File: tb/bpe_error_gen_bench.sv
module bpe_error_gen_bench;
  localparam int NN = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [1:0]    opMode = 2'b00;
  logic [7:0]    sampleIn = '0;
  logic [7:0]    dpIn = '0;
  logic [NN-1:0] selOneHot;
  logic          busy;
  logic          done;
  logic [NN*8-1:0] deltaBus;

  int checks = 0;
  int errors = 0;
  int expDelta [NN];
  int expDeriv [NN];

  always #10 clk = ~clk;   // 50 MHz

  bpe_error_gen u_bpe_error_gen (
    .clk(clk), .rstN(rstN), .start(start), .opMode(opMode),
    .sampleIn(sampleIn), .dpIn(dpIn), .selOneHot(selOneHot),
    .busy(busy), .done(done), .deltaBus(deltaBus)
  );

  function automatic int slope(int dp);
    return (dp > -32 && dp < 32) ? 16 : 0;
  endfunction

  function automatic int roundMul(int a, int d);
    int r;
    r = (a * d + 32) >>> 6;
    if (r > 127) r = 127;
    if (r < -128) r = -128;
    return r;
  endfunction

  function automatic int field(int k);
    return int'($signed(deltaBus[k*8 +: 8]));
  endfunction

  task automatic checkEq(string req, string what, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic checkAll(string req);
    for (int k = 0; k < NN; k++) checkEq(req, $sformatf("delta[%0d]", k), field(k), expDelta[k]);
  endtask

  // one pass; poke injects a capture-mode start at neuron 3
  task automatic runPass(logic [1:0] mode, int vals[NN], int dps[NN], bit poke, string req);
    @(negedge clk);
    start = 1'b1; opMode = mode;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < NN; k++) begin
      checkEq("R6", $sformatf("sel step %0d", k), int'(selOneHot), 1 << k);
      checkEq("R7", "busy in pass", int'(busy), 1);
      checkEq("R10", $sformatf("slot %0d before write", k), field(k), expDelta[k]);
      sampleIn = 8'(vals[k]);
      dpIn = 8'(dps[k]);
      if (poke && k == 3) begin start = 1'b1; opMode = 2'b01; end
      else if (poke && k == 4) begin start = 1'b0; opMode = mode; end
      case (mode)
        2'b00: expDelta[k] = roundMul(vals[k], slope(dps[k]));
        2'b01: expDeriv[k] = slope(dps[k]);
        default: expDelta[k] = roundMul(vals[k], expDeriv[k]);
      endcase
      @(negedge clk);
    end
    checkEq("R7", "done after last", int'(done), 1);
    checkEq("R7", "busy at done", int'(busy), 0);
    checkAll(req);
    @(negedge clk);
    checkEq("R7", "done one cycle", int'(done), 0);
  endtask

  task automatic testReset();
    checkEq("R1", "busy", int'(busy), 0);
    checkEq("R1", "done", int'(done), 0);
    checkEq("R1", "sel", int'(selOneHot), 0);
    for (int k = 0; k < NN; k++) begin
      expDelta[k] = 0; expDeriv[k] = 0;
    end
    checkAll("R1");
  endtask

  task automatic testSlopeTable();
    int v[NN] = '{64, 64, 64, 64, 64, 64, 64, 64};
    int d[NN] = '{-32, -31, 0, 31, 32, 127, -128, 5};
    runPass(2'b00, v, d, 1'b0, "R2");
  endtask

  task automatic testOutputMode();
    int v[NN] = '{127, -128, 1, 2, -1, -2, -3, 6};
    int d[NN] = '{0, 0, 0, 0, 0, 0, 0, 0};
    runPass(2'b00, v, d, 1'b0, "R3");
  endtask

  task automatic testCaptureHidden();
    int z[NN] = '{0, 0, 0, 0, 0, 0, 0, 0};
    int dc[NN] = '{0, 40, -31, -32, 31, 100, 10, -100};
    int s[NN] = '{100, 100, -77, -77, 55, 55, -128, 127};
    int dh[NN] = '{64, 0, 64, 0, 64, 0, 64, 0};
    runPass(2'b01, z, dc, 1'b0, "R4");
    runPass(2'b10, s, dh, 1'b0, "R5");
  endtask

  task automatic testStartWhileBusy();
    int v[NN] = '{-50, 20, 33, -9, 77, -128, 3, 90};
    int d[NN] = '{1, 2, 3, 4, 5, 6, 7, 8};
    runPass(2'b00, v, d, 1'b1, "R8");
  endtask

  task automatic testReserved();
    @(negedge clk);
    start = 1'b1; opMode = 2'b11; sampleIn = 8'd100; dpIn = 8'd0;
    @(negedge clk);
    start = 1'b0; opMode = 2'b00;
    checkEq("R9", "busy after reserved start", int'(busy), 0);
    checkEq("R9", "sel after reserved start", int'(selOneHot), 0);
    @(negedge clk);
    checkAll("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSlopeTable();
    testOutputMode();
    testCaptureHidden();
    testStartWhileBusy();
    testReserved();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule